// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block is a small direct-mapped table that the fetch stage consults every cycle with the current fetch address. The fetch address is split into three parts. The two lowest bits select a byte inside a word and play no part in the lookup. The next bits pick one slot in the table. The remaining upper bits are kept in that slot as a tag. When the slot is valid and its tag equals the tag of the fetch address, the block reports a hit and presents the stored target address as the next fetch address. Fetch can then be redirected to a taken branch before the branch has been decoded. On a miss, the next fetch address is simply the following word.

The table holds only branches that are expected to be taken, so a hit on its own means "redirect". Later in the pipeline, a resolve port reports the outcome of each branch. A taken branch writes its slot with its tag and target, replacing whatever the slot held before. A branch that turns out not taken removes its own entry, but only if the slot still belongs to that branch. The lookup path is purely combinational. Updates take effect at the next clock edge, so a lookup made in the same cycle as a write returns the contents from before that write.

Top module: `fetch_target_buffer`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses until the first taken resolution has been written.
- R2: On a miss, `pred_hit` is 0 and `pred_next_pc` equals `fetch_pc + 4`, taken modulo 2^PC_W (so 0xFFFFFFFC wraps to 0).
- R3: A resolution with `res_valid`=1 and `res_taken`=1 installs the branch. From the next cycle on, a lookup of the same word address gives `pred_hit`=1 and `pred_next_pc`=`res_target`.
- R4: A taken resolution whose slot already holds a different tag overwrites that slot. The previous branch then misses and the new branch hits with its own target.
- R5: A resolution with `res_valid`=1 and `res_taken`=0, whose slot holds a valid entry with the same tag, invalidates that entry. From the next cycle, that address misses.
- R6: A not-taken resolution whose slot holds a different tag leaves that slot unchanged.
- R7: A lookup made in the same cycle as an update to the same slot returns the slot contents from before the update.
- R8: The slot index is `pc[IDX_W+1:2]` and the tag is `pc[PC_W-1:IDX_W+2]`. Bits `pc[1:0]` are ignored. Two addresses with the same index but different tags do not hit on each other's entries.
- R9: When `res_valid`=0, the other resolve inputs have no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; invalidates all slots |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_hit | output | 1 | Lookup found a valid entry with a matching tag |
| pred_next_pc | output | PC_W | Stored target on a hit, otherwise fetch_pc + 4 |
| res_valid | input | 1 | A resolved branch is reported this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | 1 = branch was taken (install), 0 = not taken (remove own entry) |
| res_target | input | PC_W | Target of the resolved branch, stored on install |

## Verification
Directed patterns come first. One address is installed and then looked up again in the same cycle and in the next cycle, which separates correct write timing from a lookup that sees writes too early. Two addresses that share a slot but have different tags are used in turn to distinguish overwrite from a wrongly shared hit. They also separate a tag-checked removal from one that clears the slot blindly. Lookups that differ only in the byte-offset bits confirm that those bits are ignored. A resolve with the valid flag low but with taken and target driven confirms that the table does not change. A last phase drives a pseudo-random mix of lookups and resolutions over a small set of addresses, chosen so that slots collide often. That phase is compared on every clock against a behavioural table kept in the bench.

// File: rtl/ftb_pkg.sv
package ftb_pkg;

    localparam int unsigned PC_W_DEFAULT  = 32;
    localparam int unsigned IDX_W_DEFAULT = 4;
    localparam int unsigned BYTE_OFS_W    = 2;
    localparam int unsigned INSTR_BYTES   = 4;

    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_FILL = 2'd1,
        UPD_KILL = 2'd2
    } upd_op_e;

endpackage

// File: rtl/ftb_addr_split.sv
module ftb_addr_split #(
    parameter  int PC_W  = 32,
    parameter  int IDX_W = 4,
    localparam int WRD_W = PC_W - 2,
    localparam int TAG_W = PC_W - 2 - IDX_W
) (
    input  logic [WRD_W-1:0] word_addr,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);

    assign idx = word_addr[IDX_W-1:0];
    assign tag = word_addr[WRD_W-1:IDX_W];

endmodule

// File: rtl/ftb_entry_array.sv
module ftb_entry_array
    import ftb_pkg::*;
#(
    parameter  int PC_W  = 32,
    parameter  int IDX_W = 4,
    localparam int DEPTH = 1 << IDX_W,
    localparam int TAG_W = PC_W - 2 - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  upd_op_e          upd_op,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic [PC_W-1:0]  upd_tgt,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_valid,
    output logic [TAG_W-1:0] look_tag,
    output logic [PC_W-1:0]  look_tgt,
    input  logic [IDX_W-1:0] probe_idx,
    output logic             probe_valid,
    output logic [TAG_W-1:0] probe_tag
);

    typedef struct packed {
        logic [DEPTH-1:0]            valid;
        logic [DEPTH-1:0][TAG_W-1:0] tag;
        logic [DEPTH-1:0][PC_W-1:0]  tgt;
    } store_t;

    store_t           store_d;
    store_t           store_q;
    logic [DEPTH-1:0] slot_sel;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot_sel
        assign slot_sel[g] = (upd_idx == IDX_W'(g));
    end

    always_comb begin
        store_d = store_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_sel[i]) begin
                unique case (upd_op)
                    UPD_FILL: begin
                        store_d.valid[i] = 1'b1;
                        store_d.tag[i]   = upd_tag;
                        store_d.tgt[i]   = upd_tgt;
                    end
                    UPD_KILL: begin
                        store_d.valid[i] = 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    assign look_valid  = store_q.valid[look_idx];
    assign look_tag    = store_q.tag[look_idx];
    assign look_tgt    = store_q.tgt[look_idx];
    assign probe_valid = store_q.valid[probe_idx];
    assign probe_tag   = store_q.tag[probe_idx];

endmodule

// File: rtl/ftb_update_ctrl.sv
module ftb_update_ctrl
    import ftb_pkg::*;
#(
    parameter int TAG_W = 26
) (
    input  logic             res_valid,
    input  logic             res_taken,
    input  logic [TAG_W-1:0] res_tag,
    input  logic             probe_valid,
    input  logic [TAG_W-1:0] probe_tag,
    output upd_op_e          upd_op
);

    logic owner_match;

    assign owner_match = probe_valid && (probe_tag == res_tag);

    always_comb begin
        upd_op = UPD_NONE;
        if (res_valid) begin
            if (res_taken) begin
                upd_op = UPD_FILL;
            end else if (owner_match) begin
                upd_op = UPD_KILL;
            end
        end
    end

endmodule

// File: rtl/ftb_lookup.sv
module ftb_lookup
    import ftb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int TAG_W = 26
) (
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic [TAG_W-1:0] fetch_tag,
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [PC_W-1:0]  ent_tgt,
    output logic             hit,
    output logic [PC_W-1:0]  next_pc
);

    logic [PC_W-1:0] seq_pc;

    assign seq_pc  = fetch_pc + PC_W'(INSTR_BYTES);
    assign hit     = ent_valid && (ent_tag == fetch_tag);
    assign next_pc = hit ? ent_tgt : seq_pc;

endmodule

// File: rtl/fetch_target_buffer.sv
module fetch_target_buffer
    import ftb_pkg::*;
#(
    parameter  int PC_W  = PC_W_DEFAULT,
    parameter  int IDX_W = IDX_W_DEFAULT,
    localparam int TAG_W = PC_W - 2 - IDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [PC_W-1:0] res_target
);

    logic [IDX_W-1:0] f_idx;
    logic [TAG_W-1:0] f_tag;
    logic [IDX_W-1:0] r_idx;
    logic [TAG_W-1:0] r_tag;
    logic             look_valid;
    logic [TAG_W-1:0] look_tag;
    logic [PC_W-1:0]  look_tgt;
    logic             probe_valid;
    logic [TAG_W-1:0] probe_tag;
    upd_op_e          upd_op;
    logic             res_ofs_unused;

    assign res_ofs_unused = ^res_pc[1:0];

    ftb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_fetch (
        .word_addr (fetch_pc[PC_W-1:2]),
        .idx       (f_idx),
        .tag       (f_tag)
    );

    ftb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_res (
        .word_addr (res_pc[PC_W-1:2]),
        .idx       (r_idx),
        .tag       (r_tag)
    );

    ftb_entry_array #(.PC_W(PC_W), .IDX_W(IDX_W)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_op      (upd_op),
        .upd_idx     (r_idx),
        .upd_tag     (r_tag),
        .upd_tgt     (res_target),
        .look_idx    (f_idx),
        .look_valid  (look_valid),
        .look_tag    (look_tag),
        .look_tgt    (look_tgt),
        .probe_idx   (r_idx),
        .probe_valid (probe_valid),
        .probe_tag   (probe_tag)
    );

    ftb_update_ctrl #(.TAG_W(TAG_W)) u_upd (
        .res_valid   (res_valid),
        .res_taken   (res_taken),
        .res_tag     (r_tag),
        .probe_valid (probe_valid),
        .probe_tag   (probe_tag),
        .upd_op      (upd_op)
    );

    ftb_lookup #(.PC_W(PC_W), .TAG_W(TAG_W)) u_look (
        .fetch_pc  (fetch_pc),
        .fetch_tag (f_tag),
        .ent_valid (look_valid),
        .ent_tag   (look_tag),
        .ent_tgt   (look_tgt),
        .hit       (pred_hit),
        .next_pc   (pred_next_pc)
    );

endmodule

// File: rtl/ftb_checker.sv
module ftb_checker #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] fetch_pc,
    input logic            pred_hit,
    input logic [PC_W-1:0] pred_next_pc,
    input logic            res_valid,
    input logic [PC_W-1:0] res_pc,
    input logic            res_taken,
    input logic [PC_W-1:0] res_target
);

    logic first_q;
    logic chk_ofs_unused;

    assign chk_ofs_unused = ^res_pc[1:0] ^ ^IDX_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= 1'b1;
        end else begin
            first_q <= 1'b0;
        end
    end

    // R1: first cycle out of reset sees an empty table
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |-> !pred_hit);

    // R2: a miss falls through to the next word
    a_r2_miss_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> (pred_next_pc == fetch_pc + PC_W'(4)));

    // R3: a taken resolution is visible on the following cycle
    a_r3_install_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken) |=>
            ((fetch_pc[PC_W-1:2] == $past(res_pc[PC_W-1:2])) ->
                (pred_hit && (pred_next_pc == $past(res_target)))));

    // R5: a not-taken resolution leaves its own address missing
    a_r5_drop_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken) |=>
            ((fetch_pc[PC_W-1:2] == $past(res_pc[PC_W-1:2])) -> !pred_hit));

    // R9: with no resolution the lookup result for a held address is held
    a_r9_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=>
            ($stable(fetch_pc) -> ($stable(pred_hit) && $stable(pred_next_pc))));

endmodule

bind fetch_target_buffer ftb_checker #(.PC_W(PC_W), .IDX_W(IDX_W)) u_ftb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_pc     (fetch_pc),
    .pred_hit     (pred_hit),
    .pred_next_pc (pred_next_pc),
    .res_valid    (res_valid),
    .res_pc       (res_pc),
    .res_taken    (res_taken),
    .res_target   (res_target)
);

// File: tb/tb_fetch_target_buffer.sv
`timescale 1ns/1ps
module tb_fetch_target_buffer;

    localparam int PC_W  = 32;
    localparam int IDX_W = 4;
    localparam int DEPTH = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = 32'h0000_0100;
    logic            pred_hit;
    logic [PC_W-1:0] pred_next_pc;
    logic            res_valid = 1'b0;
    logic [PC_W-1:0] res_pc = '0;
    logic            res_taken = 1'b0;
    logic [PC_W-1:0] res_target = '0;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    // behavioural reference table
    bit          m_valid [DEPTH];
    logic [31:0] m_addr  [DEPTH];
    logic [31:0] m_tgt   [DEPTH];

    always #2.5 clk = ~clk;

    fetch_target_buffer #(.PC_W(PC_W), .IDX_W(IDX_W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_pc     (fetch_pc),
        .pred_hit     (pred_hit),
        .pred_next_pc (pred_next_pc),
        .res_valid    (res_valid),
        .res_pc       (res_pc),
        .res_taken    (res_taken),
        .res_target   (res_target)
    );

    function automatic int slot_of(input logic [31:0] a);
        return int'(a[5:2]);
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic act_h, input logic [31:0] act_n,
                         input logic exp_h, input logic [31:0] exp_n);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual hit=%0b next=%08h expected hit=%0b next=%08h",
                     req, act_h, act_n, exp_h, exp_n);
        end
    endtask

    // one cycle: drive, compare against model (old contents), then update model
    task automatic step(input logic [31:0] fpc, input bit rv, input bit rt,
                        input logic [31:0] rpc, input logic [31:0] rtgt,
                        input string req);
        logic        eh;
        logic [31:0] en;
        int          s;
        @(negedge clk);
        fetch_pc   = fpc;
        res_valid  = rv;
        res_taken  = rt;
        res_pc     = rpc;
        res_target = rtgt;
        #1;
        s  = slot_of(fpc);
        eh = m_valid[s] && (m_addr[s][31:6] == fpc[31:6]);
        en = eh ? m_tgt[s] : fpc + 32'd4;
        check((pred_hit === eh) && (pred_next_pc === en), req,
              pred_hit, pred_next_pc, eh, en);
        @(posedge clk);
        if (rv) begin
            s = slot_of(rpc);
            if (rt) begin
                m_valid[s] = 1'b1;
                m_addr[s]  = rpc;
                m_tgt[s]   = rtgt;
            end else if (m_valid[s] && (m_addr[s][31:6] == rpc[31:6])) begin
                m_valid[s] = 1'b0;
            end
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 1'b0;
            m_addr[i]  = '0;
            m_tgt[i]   = '0;
        end
        // R1: outputs while reset is held
        repeat (3) @(negedge clk);
        #1;
        check(pred_hit === 1'b0 && pred_next_pc === 32'h104, "R1 in reset",
              pred_hit, pred_next_pc, 1'b0, 32'h104);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: empty table, sequential fall-through and wrap
        step(32'h0000_0100, 0, 0, 0, 0, "R1 after reset");
        step(32'h0000_1000, 0, 0, 0, 0, "R1 after reset");
        step(32'hFFFF_FFFC, 0, 0, 0, 0, "R2 wrap");

        // R3 + R7: install while looking up the same address
        step(32'h0000_1000, 1, 1, 32'h0000_1000, 32'h0000_2000, "R7 same-cycle install");
        step(32'h0000_1000, 0, 0, 0, 0, "R3 installed hit");
        // R8: byte offset ignored, alias with other tag misses
        step(32'h0000_1002, 0, 0, 0, 0, "R8 offset ignored");
        step(32'h0000_1040, 0, 0, 0, 0, "R8 alias misses");
        // R6: not-taken for another tag at same slot
        step(32'h0000_1000, 1, 0, 32'h0000_1040, 32'h0, "R6 foreign drop");
        step(32'h0000_1000, 0, 0, 0, 0, "R6 entry kept");
        // R4: overwrite with a new tag
        step(32'h0000_1000, 1, 1, 32'h0000_1040, 32'h0000_3000, "R7 old before overwrite");
        step(32'h0000_1000, 0, 0, 0, 0, "R4 old branch misses");
        step(32'h0000_1040, 0, 0, 0, 0, "R4 new branch hits");
        // R5 + R7: drop own entry while looking it up
        step(32'h0000_1040, 1, 0, 32'h0000_1040, 32'h0, "R7 same-cycle drop");
        step(32'h0000_1040, 0, 0, 0, 0, "R5 dropped");
        // R9: resolve fields without valid
        step(32'h0000_1080, 0, 1, 32'h0000_1080, 32'h0000_4000, "R9 ignored");
        step(32'h0000_1080, 0, 0, 0, 0, "R9 still missing");
        // R3 at another slot, then R2 miss elsewhere
        step(32'h0000_10BC, 1, 1, 32'h0000_10BC, 32'hFFFF_FFF0, "R2 before install");
        step(32'h0000_10BC, 0, 0, 0, 0, "R3 second slot");

        // mixed phase: R3/R4/R5/R6 against the model
        lf = 32'h1ACE_B00C;
        for (int k = 0; k < 400; k++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            step(32'h0002_0000 | {24'h0, lf[5:0], 2'b00},
                 lf[16], lf[17],
                 32'h0002_0000 | {24'h0, lf[13:8], lf[1:0]},
                 {lf[31:18], 16'h0, 2'b00},
                 "R4/R5 mixed");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule